// File: doc/BRIEF.md
# Metadata Ordering Tables

This block sits beside one core of a multiprocessor in which every data word carries a security tag that a separate metadata core updates some cycles after the main core has committed the data access. Because tag work runs behind data work, two cores could see a data value and its tag in different orders. The block keeps two small tables that make tag traffic repeat the inter-core order of the data traffic. The supplier log records, for a local instruction whose data arrived from another core, which remote core supplied it. The metadata core can then find that instruction's ID and send its tag request to the matching remote metadata side. The writer log records, per address, the ID of the newest local instruction that wrote it, with a pending bit. That bit stays set until the local metadata core reports that the instruction's tag update is done.

A tag request from another core is looked up in the writer log. If a pending writer to that address is present, the request is refused (NACK) so that the requester retries later. Otherwise it is accepted (OK) and the tag can be read. Both tables are fully associative. When a table has no room, the data access that needs a new entry is held off through a ready signal.

Top module: `mdOrderTables`

## Requirements
- R1: After reset both tables are empty: reqAllocReady and wrLogReady are 1, reqLookupHit is 0, and mdRespValid and mdRespNack are 0.
- R2: An accepted supplier entry (reqAllocValid with reqAllocReady high) for ID i and source core c makes a lookup of ID i from the next cycle on return reqLookupHit=1 and reqLookupSrc=c, combinationally in the lookup cycle.
- R3: A lookup of an ID that has no live supplier entry returns reqLookupHit=0.
- R4: reqDoneValid with ID i frees the supplier entry for i; lookups of i from the next cycle miss.
- R5: With all REQ_ENTRIES supplier entries live, reqAllocReady is 0 and an allocation offered in that cycle is dropped; freeing one entry raises reqAllocReady in the following cycle.
- R6: An accepted writer record (wrLogValid with wrLogReady high) for address a sets its pending bit, so a tag request for a is answered NACK (mdRespNack=1).
- R7: A tag request for an address with no pending writer is answered OK (mdRespValid=1, mdRespNack=0).
- R8: tagDoneValid with the ID held by a pending writer entry clears it; later tag requests for that address are answered OK.
- R9: A writer record for an address already pending replaces the stored ID and uses no new entry; a completion carrying the older ID then leaves the address NACKed until the newer ID completes.
- R10: With ACK_ENTRIES pending writer entries, wrLogReady is 0 for an address not in the table and 1 for an address already in it.
- R11: Every tag request gets exactly one response in the next cycle. The response reflects the table state before that cycle's own updates: a completion in the same cycle still gives NACK, and a new writer record in the same cycle still gives OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqAllocValid | input | 1 | Log a remotely supplied data access |
| reqAllocId | input | ID_W | Instruction ID of that access |
| reqAllocSrc | input | CORE_W | Remote core that supplied the data |
| reqAllocReady | output | 1 | Supplier log has a free entry |
| reqLookupValid | input | 1 | Metadata core lookup strobe |
| reqLookupId | input | ID_W | Instruction ID to look up |
| reqLookupHit | output | 1 | Lookup found a live entry |
| reqLookupSrc | output | CORE_W | Core to send the tag request to |
| reqDoneValid | input | 1 | Tag request for an ID received OK |
| reqDoneId | input | ID_W | ID whose supplier entry is freed |
| wrLogValid | input | 1 | Log a local data write |
| wrLogAddr | input | ADDR_W | Written address |
| wrLogId | input | ID_W | ID of the writing instruction |
| wrLogReady | output | 1 | Writer record can be accepted |
| tagDoneValid | input | 1 | Local tag update finished |
| tagDoneId | input | ID_W | ID whose tag update finished |
| mdReqValid | input | 1 | Incoming tag request from a remote core |
| mdReqAddr | input | ADDR_W | Address of the tag request |
| mdRespValid | output | 1 | Response to the previous cycle's request |
| mdRespNack | output | 1 | 1 = NACK (retry), 0 = OK |

## Verification
A stale pending bit in the writer log shows at the response port on the next tag request to that address, as a NACK that never clears or an OK that comes too early. A lost or duplicated supplier entry shows in the same cycle as a wrong hit or source on a lookup. Entries that leak or are counted twice show as a ready signal that differs from the occupancy expected after a run of allocations and frees. The random phase keeps both tables near full and hits the same addresses again and again. Because of this, such faults reach the ports within a few dozen cycles.

// File: rtl/mdOrderPkg.sv
package mdOrderPkg;
  parameter int REQ_ENTRIES = 8;
  parameter int ACK_ENTRIES = 8;

  // strobes from control to datapath, one bit per table entry
  typedef struct packed {
    logic [REQ_ENTRIES-1:0] reqLoad;
    logic [REQ_ENTRIES-1:0] reqClear;
    logic [ACK_ENTRIES-1:0] ackLoad;
    logic [ACK_ENTRIES-1:0] ackClear;
  } tblStrobes_t;
endpackage

// File: rtl/mdOrderCtrl.sv
module mdOrderCtrl
  import mdOrderPkg::*;
(
  input  logic                   reqAllocValid,
  input  logic                   reqDoneValid,
  input  logic                   wrLogValid,
  input  logic                   tagDoneValid,
  input  logic [REQ_ENTRIES-1:0] reqBusy,
  input  logic [REQ_ENTRIES-1:0] reqHitDone,
  input  logic [ACK_ENTRIES-1:0] ackBusy,
  input  logic [ACK_ENTRIES-1:0] ackHitWr,
  input  logic [ACK_ENTRIES-1:0] ackHitDone,
  output logic                   reqAllocReady,
  output logic                   wrLogReady,
  output tblStrobes_t            strb
);
  logic [REQ_ENTRIES-1:0] reqFree, reqPick;
  logic [ACK_ENTRIES-1:0] ackFree, ackPick;
  logic wrHitAny;

  // lowest free slot, isolated as a one-hot vector
  assign reqFree = ~reqBusy;
  assign reqPick = reqFree & (~reqFree + REQ_ENTRIES'(1));
  assign ackFree = ~ackBusy;
  assign ackPick = ackFree & (~ackFree + ACK_ENTRIES'(1));

  assign wrHitAny      = |ackHitWr;
  assign reqAllocReady = |reqFree;
  assign wrLogReady    = wrHitAny | (|ackFree);

  always_comb begin
    strb = '0;
    if (reqAllocValid && reqAllocReady) strb.reqLoad = reqPick;
    if (reqDoneValid)                   strb.reqClear = reqHitDone;
    if (wrLogValid && wrLogReady)       strb.ackLoad = wrHitAny ? ackHitWr : ackPick;
    if (tagDoneValid)                   strb.ackClear = ackHitDone;
  end
endmodule

// File: rtl/mdOrderDp.sv
module mdOrderDp
  import mdOrderPkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16,
  parameter int CORE_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tblStrobes_t            strb,
  input  logic [ID_W-1:0]        reqAllocId,
  input  logic [CORE_W-1:0]      reqAllocSrc,
  input  logic                   reqLookupValid,
  input  logic [ID_W-1:0]        reqLookupId,
  input  logic [ID_W-1:0]        reqDoneId,
  input  logic [ADDR_W-1:0]      wrLogAddr,
  input  logic [ID_W-1:0]        wrLogId,
  input  logic [ID_W-1:0]        tagDoneId,
  input  logic                   mdReqValid,
  input  logic [ADDR_W-1:0]      mdReqAddr,
  output logic [REQ_ENTRIES-1:0] reqBusy,
  output logic [REQ_ENTRIES-1:0] reqHitLookup,
  output logic [REQ_ENTRIES-1:0] reqHitDone,
  output logic [ACK_ENTRIES-1:0] ackBusy,
  output logic [ACK_ENTRIES-1:0] ackHitWr,
  output logic [ACK_ENTRIES-1:0] ackHitDone,
  output logic                   reqLookupHit,
  output logic [CORE_W-1:0]      reqLookupSrc,
  output logic                   mdRespValid,
  output logic                   mdRespNack
);
  logic [ID_W-1:0]   reqIdQ   [REQ_ENTRIES];
  logic [CORE_W-1:0] reqSrcQ  [REQ_ENTRIES];
  logic [ID_W-1:0]   ackIdQ   [ACK_ENTRIES];
  logic [ADDR_W-1:0] ackAddrQ [ACK_ENTRIES];
  logic [ACK_ENTRIES-1:0] ackHitMd;

  for (genvar i = 0; i < REQ_ENTRIES; i++) begin : g_req
    assign reqHitLookup[i] = reqBusy[i] && reqLookupValid && (reqIdQ[i] == reqLookupId);
    assign reqHitDone[i]   = reqBusy[i] && (reqIdQ[i] == reqDoneId);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqBusy[i] <= 1'b0;
        reqIdQ[i]  <= '0;
        reqSrcQ[i] <= '0;
      end else if (strb.reqLoad[i]) begin
        reqBusy[i] <= 1'b1;
        reqIdQ[i]  <= reqAllocId;
        reqSrcQ[i] <= reqAllocSrc;
      end else if (strb.reqClear[i]) begin
        reqBusy[i] <= 1'b0;
      end
    end
  end

  for (genvar j = 0; j < ACK_ENTRIES; j++) begin : g_ack
    assign ackHitWr[j]   = ackBusy[j] && (ackAddrQ[j] == wrLogAddr);
    assign ackHitDone[j] = ackBusy[j] && (ackIdQ[j] == tagDoneId);
    assign ackHitMd[j]   = ackBusy[j] && (ackAddrQ[j] == mdReqAddr);

    // a newer writer to the same address wins over a completion
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackBusy[j]  <= 1'b0;
        ackIdQ[j]   <= '0;
        ackAddrQ[j] <= '0;
      end else if (strb.ackLoad[j]) begin
        ackBusy[j]  <= 1'b1;
        ackIdQ[j]   <= wrLogId;
        ackAddrQ[j] <= wrLogAddr;
      end else if (strb.ackClear[j]) begin
        ackBusy[j] <= 1'b0;
      end
    end
  end

  always_comb begin
    reqLookupSrc = '0;
    for (int k = 0; k < REQ_ENTRIES; k++)
      if (reqHitLookup[k]) reqLookupSrc = reqLookupSrc | reqSrcQ[k];
  end
  assign reqLookupHit = |reqHitLookup;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdRespValid <= 1'b0;
      mdRespNack  <= 1'b0;
    end else begin
      mdRespValid <= mdReqValid;
      mdRespNack  <= mdReqValid && (|ackHitMd);
    end
  end
endmodule

// File: rtl/mdOrderTables.sv
module mdOrderTables
  import mdOrderPkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16,
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqAllocValid,
  input  logic [ID_W-1:0]   reqAllocId,
  input  logic [CORE_W-1:0] reqAllocSrc,
  output logic              reqAllocReady,
  input  logic              reqLookupValid,
  input  logic [ID_W-1:0]   reqLookupId,
  output logic              reqLookupHit,
  output logic [CORE_W-1:0] reqLookupSrc,
  input  logic              reqDoneValid,
  input  logic [ID_W-1:0]   reqDoneId,
  input  logic              wrLogValid,
  input  logic [ADDR_W-1:0] wrLogAddr,
  input  logic [ID_W-1:0]   wrLogId,
  output logic              wrLogReady,
  input  logic              tagDoneValid,
  input  logic [ID_W-1:0]   tagDoneId,
  input  logic              mdReqValid,
  input  logic [ADDR_W-1:0] mdReqAddr,
  output logic              mdRespValid,
  output logic              mdRespNack
);
  tblStrobes_t            strb;
  logic [REQ_ENTRIES-1:0] reqBusy, reqHitLookup, reqHitDone;
  logic [ACK_ENTRIES-1:0] ackBusy, ackHitWr, ackHitDone;

  mdOrderCtrl ctrl_i (
    .reqAllocValid (reqAllocValid),
    .reqDoneValid  (reqDoneValid),
    .wrLogValid    (wrLogValid),
    .tagDoneValid  (tagDoneValid),
    .reqBusy       (reqBusy),
    .reqHitDone    (reqHitDone),
    .ackBusy       (ackBusy),
    .ackHitWr      (ackHitWr),
    .ackHitDone    (ackHitDone),
    .reqAllocReady (reqAllocReady),
    .wrLogReady    (wrLogReady),
    .strb          (strb)
  );

  mdOrderDp #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .reqAllocId     (reqAllocId),
    .reqAllocSrc    (reqAllocSrc),
    .reqLookupValid (reqLookupValid),
    .reqLookupId    (reqLookupId),
    .reqDoneId      (reqDoneId),
    .wrLogAddr      (wrLogAddr),
    .wrLogId        (wrLogId),
    .tagDoneId      (tagDoneId),
    .mdReqValid     (mdReqValid),
    .mdReqAddr      (mdReqAddr),
    .reqBusy        (reqBusy),
    .reqHitLookup   (reqHitLookup),
    .reqHitDone     (reqHitDone),
    .ackBusy        (ackBusy),
    .ackHitWr       (ackHitWr),
    .ackHitDone     (ackHitDone),
    .reqLookupHit   (reqLookupHit),
    .reqLookupSrc   (reqLookupSrc),
    .mdRespValid    (mdRespValid),
    .mdRespNack     (mdRespNack)
  );
endmodule

// File: rtl/mdOrderTablesChk.sv
module mdOrderTablesChk
  import mdOrderPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   mdReqValid,
  input logic                   mdRespValid,
  input logic                   mdRespNack,
  input logic                   reqAllocValid,
  input logic                   reqAllocReady,
  input logic                   reqDoneValid,
  input logic                   wrLogValid,
  input logic                   wrLogReady,
  input logic                   tagDoneValid,
  input logic [REQ_ENTRIES-1:0] reqBusy,
  input logic [REQ_ENTRIES-1:0] reqHitLookup,
  input logic [ACK_ENTRIES-1:0] ackBusy,
  input logic [ACK_ENTRIES-1:0] ackHitWr
);
  // R11
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdReqValid |=> mdRespValid);
  // R11
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mdReqValid |=> !mdRespValid);
  // R7
  no_stray_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mdReqValid |=> !mdRespNack);
  // R3
  unique_id_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqHitLookup));
  // R9
  unique_addr_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackHitWr));
  // R5
  full_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAllocValid && !reqAllocReady && !reqDoneValid |=> $stable(reqBusy));
  // R10
  full_ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLogValid && !wrLogReady && !tagDoneValid |=> $stable(ackBusy));
  // R6
  writer_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLogValid && wrLogReady |=> (ackBusy != '0));
endmodule

bind mdOrderTables mdOrderTablesChk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .mdReqValid    (mdReqValid),
  .mdRespValid   (mdRespValid),
  .mdRespNack    (mdRespNack),
  .reqAllocValid (reqAllocValid),
  .reqAllocReady (reqAllocReady),
  .reqDoneValid  (reqDoneValid),
  .wrLogValid    (wrLogValid),
  .wrLogReady    (wrLogReady),
  .tagDoneValid  (tagDoneValid),
  .reqBusy       (reqBusy),
  .reqHitLookup  (reqHitLookup),
  .ackBusy       (ackBusy),
  .ackHitWr      (ackHitWr)
);

// File: tb/mdOrderTables_tb.sv
module mdOrderTables_tb_top;
  localparam int ID_W = 8, ADDR_W = 16, CORE_W = 2, NR = 8, NA = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqAllocValid, reqLookupValid, reqDoneValid, wrLogValid, tagDoneValid, mdReqValid;
  logic [ID_W-1:0] reqAllocId, reqLookupId, reqDoneId, wrLogId, tagDoneId;
  logic [CORE_W-1:0] reqAllocSrc;
  logic [ADDR_W-1:0] wrLogAddr, mdReqAddr;
  logic reqAllocReady, reqLookupHit, wrLogReady, mdRespValid, mdRespNack;
  logic [CORE_W-1:0] reqLookupSrc;

  always #2 clk = ~clk;

  mdOrderTables #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) dut_i (.*);

  int compared = 0, mismatched = 0;
  // reference model of the two tables
  bit mReqBusy[NR]; int mReqId[NR]; int mReqSrc[NR];
  bit mAckBusy[NA]; int mAckAddr[NA]; int mAckId[NA];
  bit prevReqV = 0, prevNack = 0;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    reqAllocValid = 0; reqAllocId = '0; reqAllocSrc = '0;
    reqLookupValid = 0; reqLookupId = '0;
    reqDoneValid = 0; reqDoneId = '0;
    wrLogValid = 0; wrLogAddr = '0; wrLogId = '0;
    tagDoneValid = 0; tagDoneId = '0;
    mdReqValid = 0; mdReqAddr = '0;
  endtask

  function automatic int reqFreeSlot();
    for (int i = 0; i < NR; i++) if (!mReqBusy[i]) return i;
    return -1;
  endfunction
  function automatic int ackFreeSlot();
    for (int i = 0; i < NA; i++) if (!mAckBusy[i]) return i;
    return -1;
  endfunction
  function automatic int ackFindAddr(int a);
    for (int i = 0; i < NA; i++) if (mAckBusy[i] && mAckAddr[i] == a) return i;
    return -1;
  endfunction
  function automatic int reqFindId(int id);
    for (int i = 0; i < NR; i++) if (mReqBusy[i] && mReqId[i] == id) return i;
    return -1;
  endfunction

  // called just after a falling edge with inputs set; returns at the next falling edge
  task automatic step(string tag);
    int rFree, aFree, aHit, lk;
    bit eReqRdy, eWrRdy, eNack;
    #1;
    rFree = reqFreeSlot(); aFree = ackFreeSlot(); aHit = ackFindAddr(int'(wrLogAddr));
    eReqRdy = (rFree >= 0);
    eWrRdy  = (aHit >= 0) || (aFree >= 0);
    lk = reqFindId(int'(reqLookupId));
    eNack = mdReqValid && (ackFindAddr(int'(mdReqAddr)) >= 0);
    chk(tag, "reqAllocReady", int'(reqAllocReady), int'(eReqRdy));
    chk(tag, "wrLogReady", int'(wrLogReady), int'(eWrRdy));
    chk(tag, "reqLookupHit", int'(reqLookupHit), int'(reqLookupValid && lk >= 0));
    if (reqLookupValid && lk >= 0) chk(tag, "reqLookupSrc", int'(reqLookupSrc), mReqSrc[lk]);
    chk(tag, "mdRespValid", int'(mdRespValid), int'(prevReqV));
    chk(tag, "mdRespNack", int'(mdRespNack), int'(prevNack));
    @(posedge clk);
    // supplier log update
    if (reqDoneValid)
      for (int i = 0; i < NR; i++) if (mReqBusy[i] && mReqId[i] == int'(reqDoneId)) mReqBusy[i] = 0;
    if (reqAllocValid && eReqRdy) begin
      mReqBusy[rFree] = 1; mReqId[rFree] = int'(reqAllocId); mReqSrc[rFree] = int'(reqAllocSrc);
    end
    // writer log update: a newer writer beats a completion
    for (int i = 0; i < NA; i++) begin
      if (wrLogValid && eWrRdy && i == aHit) mAckId[i] = int'(wrLogId);
      else if (tagDoneValid && mAckBusy[i] && mAckId[i] == int'(tagDoneId)) mAckBusy[i] = 0;
    end
    if (wrLogValid && eWrRdy && aHit < 0) begin
      mAckBusy[aFree] = 1; mAckAddr[aFree] = int'(wrLogAddr); mAckId[aFree] = int'(wrLogId);
    end
    prevReqV = mdReqValid; prevNack = eNack;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int wid;
    void'($urandom(32'h5eed_0042));
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: empty tables after reset
    step("R1");
    // R2: log ID 5 from core 2, then look it up
    reqAllocValid = 1; reqAllocId = 5; reqAllocSrc = 2; step("R2"); idle();
    reqLookupValid = 1; reqLookupId = 5; step("R2");
    // R3: unknown ID misses
    reqLookupId = 6; step("R3"); idle();
    // R4: free ID 5, lookup misses
    reqDoneValid = 1; reqDoneId = 5; step("R4"); idle();
    reqLookupValid = 1; reqLookupId = 5; step("R4"); idle();
    // R5: fill the supplier log, extra allocation dropped
    for (int i = 0; i < NR; i++) begin
      reqAllocValid = 1; reqAllocId = ID_W'(100 + i); reqAllocSrc = CORE_W'(i); step("R5");
    end
    reqAllocId = 120; reqAllocSrc = 1; step("R5"); idle();
    reqLookupValid = 1; reqLookupId = 120; step("R5"); idle();
    reqDoneValid = 1; reqDoneId = 103; step("R5"); idle();
    step("R5");
    // R6: pending writer NACKs a tag request
    wrLogValid = 1; wrLogAddr = 3; wrLogId = 20; step("R6"); idle();
    mdReqValid = 1; mdReqAddr = 3; step("R6"); idle();
    step("R6");
    // R7: address not logged answers OK
    mdReqValid = 1; mdReqAddr = 4; step("R7"); idle();
    step("R7");
    // R9: newer writer replaces ID; old completion leaves NACK
    wrLogValid = 1; wrLogAddr = 3; wrLogId = 21; step("R9"); idle();
    tagDoneValid = 1; tagDoneId = 20; step("R9"); idle();
    mdReqValid = 1; mdReqAddr = 3; step("R9"); idle();
    // R8: completion of current writer clears
    tagDoneValid = 1; tagDoneId = 21; step("R8"); idle();
    mdReqValid = 1; mdReqAddr = 3; step("R8"); idle();
    step("R8");
    // R11: same-cycle writer record still OK, same-cycle completion still NACK
    wrLogValid = 1; wrLogAddr = 7; wrLogId = 30; mdReqValid = 1; mdReqAddr = 7; step("R11"); idle();
    tagDoneValid = 1; tagDoneId = 30; mdReqValid = 1; mdReqAddr = 7; step("R11"); idle();
    mdReqValid = 1; mdReqAddr = 7; step("R11"); idle();
    step("R11");
    // R10: full writer log
    for (int i = 0; i < NA; i++) begin
      wrLogValid = 1; wrLogAddr = ADDR_W'(40 + i); wrLogId = ID_W'(50 + i); step("R10");
    end
    wrLogAddr = 48; wrLogId = 60; step("R10");
    wrLogAddr = 40; wrLogId = 61; step("R10"); idle();
    mdReqValid = 1; mdReqAddr = 48; step("R10"); idle();
    step("R10");

    // random phase over all ports
    wid = 70;
    for (int n = 0; n < 4000; n++) begin
      int rid;
      idle();
      rid = int'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0 && reqFindId(rid) < 0) begin
        reqAllocValid = 1; reqAllocId = ID_W'(rid); reqAllocSrc = CORE_W'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 2) == 0) begin
        int d = int'($urandom_range(0, 15));
        if (!(reqAllocValid && d == rid)) begin reqDoneValid = 1; reqDoneId = ID_W'(d); end
      end
      reqLookupValid = 1'($urandom_range(0, 1)); reqLookupId = ID_W'($urandom_range(0, 15));
      if ($urandom_range(0, 4) < 2) begin
        wrLogValid = 1; wrLogAddr = ADDR_W'($urandom_range(0, 11)); wrLogId = ID_W'(wid);
        wid = (wid + 1) % 256;
      end
      if ($urandom_range(0, 1) == 1) begin
        int s = int'($urandom_range(0, NA - 1));
        tagDoneValid = 1;
        tagDoneId = mAckBusy[s] ? ID_W'(mAckId[s]) : ID_W'($urandom_range(0, 255));
      end
      mdReqValid = 1'($urandom_range(0, 1)); mdReqAddr = ADDR_W'($urandom_range(0, 11));
      step("R2/R4/R6/R8/R9 random");
    end
    idle();
    step("R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule